// File: doc/BRIEF.md
# Monochrome Page-RAM Raster Scanner

This block holds a monochrome display memory organised as 8 pages of 132 byte columns, where each byte carries 8 vertically stacked pixels (bit 0 topmost). A byte write port fills the memory. A scan engine turns a 96-column by 16-row window of it into a raster pixel stream. Each window pixel is repeated `REP` times across and each window row `REP` times down. With the default `REP = 4` the stream is 384 by 64 pixels; `REP = 1` gives the bare window.

A frame is scanned only when the memory is dirty. An accepted write or a one-cycle `invalidate` pulse marks it dirty, and a finished frame clears the mark. The frame reads the line offset, the inverse flag and the all-lit override once, when it starts. Each output pixel comes with valid, start-of-line and start-of-frame markers. A ready input from the sink holds the whole pipeline without losing or repeating any pixel.

Top module: `fbscan_top`

## Requirements
- R1: A write with `wr_en` high and `wr_col` below 132 stores `wr_data` at (`wr_page`, `wr_col`). A write with `wr_col` of 132 or more changes no memory byte and does not mark the memory dirty.
- R2: An accepted write or an `invalidate` pulse marks the memory dirty. A frame starts only while the memory is dirty, and `pix_valid` stays low when it is not.
- R3: Completing a frame clears the dirty mark. The exception is a write or invalidate that arrives while the frame is being scanned: exactly one more frame then follows.
- R4: A frame is `96*REP` by `16*REP` pixels in raster order. Output pixel (ox, oy) shows window column `ox/REP` of window row `oy/REP`.
- R5: Window row y shows memory line `(y + start_line) mod 64`. That line is bit `line mod 8` of the byte in page `line/8`.
- R6: Window column x reads memory column `x + 36`.
- R7: With `inverse` low, a stored 1 bit gives `pix_data` 1. With `inverse` high, a stored 1 bit gives `pix_data` 0.
- R8: With `all_on` high, every pixel of the frame is 1, whatever the memory holds and whatever `inverse` is.
- R9: `start_line`, `inverse` and `all_on` are sampled when a frame starts. Changing them during a frame affects only later frames.
- R10: `pix_sol` is high with the first pixel of each output line. `pix_sof` is high only with the first pixel of a frame. Neither is ever high without `pix_valid`.
- R11: While `pix_valid` is high and `pix_ready` is low, `pix_valid`, `pix_data`, `pix_sol` and `pix_sof` hold their values. Every pixel is delivered exactly once.
- R12: During and right after reset, `pix_valid`, `pix_sol` and `pix_sof` are low and the memory is not dirty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| wr_page | input | 3 | Page of the written byte |
| wr_col | input | 8 | Column of the written byte |
| wr_data | input | 8 | Byte value, bit 0 topmost pixel |
| start_line | input | 6 | Line shown in window row 0 |
| inverse | input | 1 | Invert stored pixels |
| all_on | input | 1 | Force every pixel lit |
| invalidate | input | 1 | Request a new frame |
| pix_ready | input | 1 | Sink accepts the current pixel |
| pix_valid | output | 1 | Pixel present |
| pix_data | output | 1 | Pixel value, 1 = lit |
| pix_sol | output | 1 | First pixel of an output line |
| pix_sof | output | 1 | First pixel of a frame |

## Verification
The hardest case to reach is a dirty event that lands while a frame is still in flight. Without the pending record, that event would be absorbed silently by the clear at frame end. The bench reaches it in two ways. It loads the whole memory while the sink holds ready low, so the first write starts a frame that stalls after a few reads and every later write falls inside it. It also pulses invalidate and changes the settings partway through a captured frame. In both cases it checks that exactly one further frame follows, built with the new settings, and that nothing follows that frame.

// File: rtl/fbscan_pkg.sv
package fbscan_pkg;

  localparam int BYTE_BITS = 8;
  localparam int BIT_W     = 3;

  typedef struct packed {
    logic vld;
    logic sol;
    logic sof;
  } mark_t;

  typedef struct packed {
    logic inv;
    logic lit_all;
  } mode_t;

endpackage

// File: rtl/fbscan_ram.sv
module fbscan_ram #(
  parameter int DEPTH  = 1056,
  parameter int ADDR_W = 11,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DW-1:0]     rd_data
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // registered read, read-first on a same-address collision
  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/fbscan_seq.sv
module fbscan_seq
  import fbscan_pkg::*;
#(
  parameter int WIN_W   = 96,
  parameter int WIN_H   = 16,
  parameter int REP     = 4,
  parameter int LINES   = 64,
  parameter int COL_OFS = 36,
  parameter int COL_W   = 8,
  parameter int LINE_W  = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    dirty_i,
  input  logic                    adv_i,
  input  logic [LINE_W-1:0]       start_line_i,
  input  logic                    inverse_i,
  input  logic                    all_on_i,
  output logic                    act_o,
  output logic                    done_o,
  output logic [LINE_W-BIT_W-1:0] page_o,
  output logic [COL_W-1:0]        col_o,
  output logic [BIT_W-1:0]        bit_o,
  output mark_t                   mark_o,
  output mode_t                   mode_o
);

  localparam int XR_W = (REP > 1) ? $clog2(REP) : 1;
  localparam int XC_W = (WIN_W > 1) ? $clog2(WIN_W) : 1;
  localparam int YC_W = (WIN_H > 1) ? $clog2(WIN_H) : 1;

  logic [XR_W-1:0]   xr, yr;
  logic [XC_W-1:0]   xc;
  logic [YC_W-1:0]   yc;
  logic [LINE_W-1:0] sl_q;
  logic              act_q;
  logic              x_wrap, xc_last, y_wrap, yc_last, at_end;
  logic [LINE_W:0]   line_sum, line_red;
  logic [LINE_W-1:0] line;

  assign x_wrap  = (xr == XR_W'(REP - 1));
  assign xc_last = (xc == XC_W'(WIN_W - 1));
  assign y_wrap  = (yr == XR_W'(REP - 1));
  assign yc_last = (yc == YC_W'(WIN_H - 1));
  assign at_end  = x_wrap && xc_last && y_wrap && yc_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      xr     <= '0;
      xc     <= '0;
      yr     <= '0;
      yc     <= '0;
      sl_q   <= '0;
      mode_o <= '0;
    end else if (!act_q) begin
      if (dirty_i) begin
        act_q          <= 1'b1;
        xr             <= '0;
        xc             <= '0;
        yr             <= '0;
        yc             <= '0;
        sl_q           <= start_line_i;
        mode_o.inv     <= inverse_i;
        mode_o.lit_all <= all_on_i;
      end
    end else if (adv_i) begin
      if (x_wrap) begin
        xr <= '0;
        if (xc_last) begin
          xc <= '0;
          if (y_wrap) begin
            yr <= '0;
            if (yc_last) begin
              yc    <= '0;
              act_q <= 1'b0;
            end else begin
              yc <= yc + 1'b1;
            end
          end else begin
            yr <= yr + 1'b1;
          end
        end else begin
          xc <= xc + 1'b1;
        end
      end else begin
        xr <= xr + 1'b1;
      end
    end
  end

  // line = (row + offset) mod LINES, both operands below LINES
  assign line_sum = (LINE_W + 1)'(yc) + (LINE_W + 1)'(sl_q);
  assign line_red = (line_sum >= (LINE_W + 1)'(LINES)) ? line_sum - (LINE_W + 1)'(LINES) : line_sum;
  assign line     = line_red[LINE_W-1:0];

  assign page_o = line[LINE_W-1:BIT_W];
  assign bit_o  = line[BIT_W-1:0];
  assign col_o  = COL_W'(xc) + COL_W'(COL_OFS);

  assign mark_o.vld = act_q;
  assign mark_o.sol = act_q && (xr == '0) && (xc == '0);
  assign mark_o.sof = act_q && (xr == '0) && (xc == '0) && (yr == '0) && (yc == '0);

  assign act_o  = act_q;
  assign done_o = act_q && adv_i && at_end;

endmodule

// File: rtl/fbscan_shade.sv
module fbscan_shade
  import fbscan_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 adv_i,
  input  mark_t                mark_i,
  input  mode_t                mode_i,
  input  logic [BIT_W-1:0]     bit_i,
  input  logic [BYTE_BITS-1:0] byte_i,
  output logic                 pix_valid,
  output logic                 pix_data,
  output logic                 pix_sol,
  output logic                 pix_sof
);

  // stage 1 travels alongside the memory read
  mark_t            m1;
  mode_t            md1;
  logic [BIT_W-1:0] b1;
  logic             raw_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      m1  <= '0;
      md1 <= '0;
      b1  <= '0;
    end else if (adv_i) begin
      m1  <= mark_i;
      md1 <= mode_i;
      b1  <= bit_i;
    end
  end

  assign raw_bit = byte_i[b1];

  // stage 2: registered pixel with its markers
  always_ff @(posedge clk) begin
    if (rst) begin
      pix_valid <= 1'b0;
      pix_data  <= 1'b0;
      pix_sol   <= 1'b0;
      pix_sof   <= 1'b0;
    end else if (adv_i) begin
      pix_valid <= m1.vld;
      pix_sol   <= m1.sol;
      pix_sof   <= m1.sof;
      pix_data  <= m1.vld && (md1.lit_all || (raw_bit ^ md1.inv));
    end
  end

endmodule

// File: rtl/fbscan_top.sv
module fbscan_top
  import fbscan_pkg::*;
#(
  parameter int PAGES   = 8,
  parameter int COLS    = 132,
  parameter int WIN_W   = 96,
  parameter int WIN_H   = 16,
  parameter int COL_OFS = 36,
  parameter int REP     = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [$clog2(PAGES)-1:0]      wr_page,
  input  logic [$clog2(COLS)-1:0]       wr_col,
  input  logic [7:0]                    wr_data,
  input  logic [$clog2(PAGES*8)-1:0]    start_line,
  input  logic                          inverse,
  input  logic                          all_on,
  input  logic                          invalidate,
  input  logic                          pix_ready,
  output logic                          pix_valid,
  output logic                          pix_data,
  output logic                          pix_sol,
  output logic                          pix_sof
);

  localparam int PAGE_W = $clog2(PAGES);
  localparam int COL_W  = $clog2(COLS);
  localparam int LINES  = PAGES * BYTE_BITS;
  localparam int LINE_W = $clog2(LINES);
  localparam int DEPTH  = PAGES * COLS;
  localparam int ADDR_W = $clog2(DEPTH);

  logic              adv, wr_ok, set_dirty;
  logic              dirty_q, pend_q;
  logic              scan_act, frame_done;
  logic [PAGE_W-1:0] rd_page;
  logic [COL_W-1:0]  rd_col;
  logic [BIT_W-1:0]  rd_bit;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [7:0]        rd_byte;
  mark_t             mark0;
  mode_t             mode0;

  assign adv = !pix_valid || pix_ready;

  assign wr_ok     = wr_en && (wr_col < COL_W'(COLS)) &&
                     ({1'b0, wr_page} < (PAGE_W + 1)'(PAGES));
  assign set_dirty = wr_ok || invalidate;

  // dirty mark with a one-deep pending record for events inside a frame
  always_ff @(posedge clk) begin
    if (rst) begin
      dirty_q <= 1'b0;
      pend_q  <= 1'b0;
    end else if (frame_done) begin
      dirty_q <= pend_q || set_dirty;
      pend_q  <= 1'b0;
    end else begin
      if (set_dirty)             dirty_q <= 1'b1;
      if (set_dirty && scan_act) pend_q  <= 1'b1;
    end
  end

  assign wr_addr = ADDR_W'(wr_page) * ADDR_W'(COLS) + ADDR_W'(wr_col);
  assign rd_addr = ADDR_W'(rd_page) * ADDR_W'(COLS) + ADDR_W'(rd_col);

  fbscan_ram #(
    .DEPTH  (DEPTH),
    .ADDR_W (ADDR_W),
    .DW     (BYTE_BITS)
  ) u_ram (
    .clk     (clk),
    .wr_en   (wr_ok),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_en   (adv),
    .rd_addr (rd_addr),
    .rd_data (rd_byte)
  );

  fbscan_seq #(
    .WIN_W   (WIN_W),
    .WIN_H   (WIN_H),
    .REP     (REP),
    .LINES   (LINES),
    .COL_OFS (COL_OFS),
    .COL_W   (COL_W),
    .LINE_W  (LINE_W)
  ) u_seq (
    .clk          (clk),
    .rst          (rst),
    .dirty_i      (dirty_q),
    .adv_i        (adv),
    .start_line_i (start_line),
    .inverse_i    (inverse),
    .all_on_i     (all_on),
    .act_o        (scan_act),
    .done_o       (frame_done),
    .page_o       (rd_page),
    .col_o        (rd_col),
    .bit_o        (rd_bit),
    .mark_o       (mark0),
    .mode_o       (mode0)
  );

  fbscan_shade u_shade (
    .clk       (clk),
    .rst       (rst),
    .adv_i     (adv),
    .mark_i    (mark0),
    .mode_i    (mode0),
    .bit_i     (rd_bit),
    .byte_i    (rd_byte),
    .pix_valid (pix_valid),
    .pix_data  (pix_data),
    .pix_sol   (pix_sol),
    .pix_sof   (pix_sof)
  );

endmodule

// File: rtl/fbscan_chk.sv
module fbscan_chk (
  input logic clk,
  input logic rst,
  input logic pix_valid,
  input logic pix_ready,
  input logic pix_data,
  input logic pix_sol,
  input logic pix_sof,
  input logic scan_act,
  input logic dirty,
  input logic pend,
  input logic set_dirty
);

  AST_SOF_WITH_SOL: assert property (@(posedge clk) disable iff (rst)
    pix_sof |-> (pix_sol && pix_valid)); // R10

  AST_SOL_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    pix_sol |-> pix_valid); // R10

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_data) &&
                                   $stable(pix_sol) && $stable(pix_sof))); // R11

  AST_START_NEEDS_DIRTY: assert property (@(posedge clk) disable iff (rst)
    $rose(scan_act) |-> $past(dirty)); // R2

  AST_CLEAR_AT_END: assert property (@(posedge clk) disable iff (rst)
    ($fell(scan_act) && !$past(set_dirty) && !$past(pend)) |-> !dirty); // R3

endmodule

bind fbscan_top fbscan_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .pix_valid (pix_valid),
  .pix_ready (pix_ready),
  .pix_data  (pix_data),
  .pix_sol   (pix_sol),
  .pix_sof   (pix_sof),
  .scan_act  (scan_act),
  .dirty     (dirty_q),
  .pend      (pend_q),
  .set_dirty (set_dirty)
);

// File: tb/fbscan_top_tb.sv
`timescale 1ns/1ps
module fbscan_top_tb;

  localparam int TB_REP = 2;
  localparam int FW     = 96 * TB_REP;
  localparam int FH     = 16 * TB_REP;
  localparam int TOT    = FW * FH;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_page = '0;
  logic [7:0] wr_col = '0;
  logic [7:0] wr_data = '0;
  logic [5:0] start_line = '0;
  logic       inverse = 1'b0;
  logic       all_on = 1'b0;
  logic       invalidate = 1'b0;
  logic       pix_ready = 1'b0;
  logic       pix_valid, pix_data, pix_sol, pix_sof;

  int checks = 0;
  int fails  = 0;
  logic [7:0]  shadow [8][132];
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  fbscan_top #(.REP(TB_REP)) u_dut (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_page    (wr_page),
    .wr_col     (wr_col),
    .wr_data    (wr_data),
    .start_line (start_line),
    .inverse    (inverse),
    .all_on     (all_on),
    .invalidate (invalidate),
    .pix_ready  (pix_ready),
    .pix_valid  (pix_valid),
    .pix_data   (pix_data),
    .pix_sol    (pix_sol),
    .pix_sof    (pix_sof)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit exp_pix(input int n, input int sl, input bit inv, input bit on);
    int x, y, line;
    x    = (n % FW) / TB_REP;
    y    = (n / FW) / TB_REP;
    line = (y + sl) % 64;
    if (on) return 1'b1;
    return shadow[line / 8][x + 36][line % 8] ^ inv;
  endfunction

  task automatic write_byte(input int p, input int c, input logic [7:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_page = 3'(p);
    wr_col  = 8'(c);
    wr_data = d;
    if (c < 132) shadow[p][c] = d;
  endtask

  task automatic write_end();
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_invalidate();
    @(negedge clk);
    invalidate = 1'b1;
    @(negedge clk);
    invalidate = 1'b0;
  endtask

  // no frame may appear within the window while the sink is ready
  task automatic expect_idle(input int cyc, input string tag);
    int seen = 0;
    @(negedge clk);
    pix_ready = 1'b1;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (pix_valid) seen++;
    end
    pix_ready = 1'b0;
    chk(seen == 0, tag, "valid pixels while not dirty", seen, 0);
  endtask

  // collect one frame; optionally change settings and invalidate mid-frame
  task automatic capture(input bit chk_data, input int sl, input bit inv, input bit on,
                         input bit rnd, input int change_at, input string tag);
    int  n = 0, guard = 0, bad_d = 0, bad_m = 0, bad_h = 0, first = -1;
    bit  prev_stall = 1'b0, clr_inv = 1'b0;
    logic pd = 1'b0, ps = 1'b0, pf = 1'b0;
    while (n < TOT && guard < TOT * 5 + 2000) begin
      @(negedge clk);
      guard++;
      if (clr_inv) begin
        invalidate = 1'b0;
        clr_inv    = 1'b0;
      end
      if (prev_stall) begin
        if (!pix_valid || pix_data !== pd || pix_sol !== ps || pix_sof !== pf) bad_h++;
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      pix_ready = rnd ? (lfsr[0] | lfsr[5]) : 1'b1;
      prev_stall = pix_valid && !pix_ready;
      pd = pix_data; ps = pix_sol; pf = pix_sof;
      if (pix_valid && pix_ready) begin
        if (pix_sof !== (n == 0) || pix_sol !== ((n % FW) == 0)) bad_m++;
        if (chk_data && pix_data !== exp_pix(n, sl, inv, on)) begin
          bad_d++;
          if (first < 0) first = n;
        end
        if (n == change_at) begin
          inverse    = ~inverse;
          start_line = 6'd20;
          invalidate = 1'b1;
          clr_inv    = 1'b1;
        end
        n++;
      end
    end
    @(negedge clk);
    pix_ready  = 1'b0;
    invalidate = 1'b0;
    chk(n == TOT, {tag, " R4"}, "pixels in frame", n, TOT);
    chk(bad_m == 0, {tag, " R10"}, "marker errors", bad_m, 0);
    if (rnd) chk(bad_h == 0, {tag, " R11"}, "stalled outputs changed", bad_h, 0);
    if (chk_data)
      chk(bad_d == 0, tag, $sformatf("data mismatches, first at pixel %0d", first), bad_d, 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(pix_valid == 1'b0, "R12", "pix_valid in reset", int'(pix_valid), 0);
    chk(pix_sol == 1'b0 && pix_sof == 1'b0, "R12", "markers in reset",
        int'({pix_sol, pix_sof}), 0);
    rst = 1'b0;
    expect_idle(100, "R12 R2");
  endtask

  task automatic t_load();
    for (int p = 0; p < 8; p++)
      for (int c = 0; c < 132; c++)
        write_byte(p, c, 8'((p * 53 + c * 29 + 7) ^ (c * 3 >> 1)));
    write_end();
    capture(1'b0, 0, 1'b0, 1'b0, 1'b0, -1, "R3");
    capture(1'b1, 0, 1'b0, 1'b0, 1'b0, -1, "R1 R3 R5 R6 R7");
    expect_idle(200, "R3");
  endtask

  task automatic t_offset();
    @(negedge clk);
    start_line = 6'd13;
    pulse_invalidate();
    capture(1'b1, 13, 1'b0, 1'b0, 1'b0, -1, "R2 R5");
    @(negedge clk);
    start_line = 6'd60;
    inverse    = 1'b1;
    pulse_invalidate();
    capture(1'b1, 60, 1'b1, 1'b0, 1'b0, -1, "R5 R7");
  endtask

  task automatic t_all_on();
    @(negedge clk);
    all_on = 1'b1;
    pulse_invalidate();
    capture(1'b1, 60, 1'b1, 1'b1, 1'b0, -1, "R8");
    @(negedge clk);
    all_on     = 1'b0;
    inverse    = 1'b0;
    start_line = 6'd0;
  endtask

  task automatic t_bad_write();
    write_byte(0, 168, ~shadow[1][36]);
    write_end();
    expect_idle(100, "R1");
    pulse_invalidate();
    capture(1'b1, 0, 1'b0, 1'b0, 1'b0, -1, "R1");
  endtask

  task automatic t_stall();
    @(negedge clk);
    start_line = 6'd5;
    pulse_invalidate();
    capture(1'b1, 5, 1'b0, 1'b0, 1'b1, -1, "R11");
    @(negedge clk);
    start_line = 6'd0;
  endtask

  task automatic t_midframe();
    pulse_invalidate();
    capture(1'b1, 0, 1'b0, 1'b0, 1'b0, 1000, "R9");
    capture(1'b1, 20, 1'b1, 1'b0, 1'b0, -1, "R3 R9");
    expect_idle(200, "R3");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_load();
    t_offset();
    t_all_on();
    t_bad_write();
    t_stall();
    t_midframe();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule